// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit linear address into the page-table entry that maps it. A small direct-mapped translation cache is checked first. On a hit, the cached entry is returned one cycle after the request is accepted, with no memory traffic. On a miss, the block walks a two-level structure in memory through a single-outstanding request/acknowledge port. It reads the directory entry and then the table entry. Where an accessed flag is still clear, it writes the entry back with the flag set. It then combines the permission bits of both levels and fills the cache with the result.

Every response carries a page-fault flag and a 3-bit error code. Both are derived from the returned entry, the request's write flag, the current privilege level and the write-protect enable. A flush input drops every cached translation. A new request is only taken while `busy_o` is low.

Entry layout used throughout: bit 0 present, bit 1 writable, bit 2 user, bit 5 accessed, bit 6 dirty, bits [31:12] frame number. The linear address splits into the directory index [31:22], the table index [21:12] and the page offset [11:0].

Top module: `pt_walker`

## Requirements
- R1: After reset, `resp_valid_o`, `mem_req_o` and `busy_o` are low.
- R2: A request whose page is held in the cache is answered in the cycle after acceptance, with the stored entry, and without any memory access.
- R3: On a miss, the first read goes to `dir_base_i` + 4 × address[31:22]. The table read goes to (directory entry[31:12] << 12) + 4 × address[21:12].
- R4: If the directory entry or the table entry has bit 0 clear, the walk ends at that read and the returned entry is all zeros.
- R5: An entry read with bit 5 clear is written back to the address it was read from, with bit 5 set, before the walk goes on. An entry with bit 5 already set causes no write.
- R6: On a write request, the returned table entry has bit 6 set, and so does the table write-back when one occurs.
- R7: Returned bit 1 is the AND of bit 1 of both levels. Returned bit 2 is the AND of bit 2 of both levels. All other bits come from the table entry, plus bit 5 set.
- R8: `resp_fault_o` is set when returned bit 0 is clear, or when bit 2 is clear and the privilege level is not 0, or when the request is a write with write-protect enabled and bit 1 clear. `resp_err_o` is the returned entry's bits [2:0].
- R9: Only translations with both levels present enter the cache. Two pages sharing a cache slot evict each other, and a not-present page is walked again on every request.
- R10: A pulse on `flush_i` while idle makes the next request for any page miss.
- R11: `mem_req_o` stays high with stable address, write flag and write data until `mem_ack_i`, and only one access is outstanding at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request, taken while busy_o is low |
| req_addr_i | input | 32 | Linear address |
| req_write_i | input | 1 | Request is a write |
| req_priv_i | input | 2 | Current privilege level (0 = supervisor) |
| dir_base_i | input | 32 | Physical base of the directory |
| wp_en_i | input | 1 | Write-protect enable for writable-bit checks |
| flush_i | input | 1 | Invalidate every cache slot |
| busy_o | output | 1 | A request is in progress |
| resp_valid_o | output | 1 | One-cycle response strobe |
| resp_entry_o | output | 32 | Combined entry, zero if not present |
| resp_fault_o | output | 1 | Page fault |
| resp_err_o | output | 3 | Fault error code |
| mem_req_o | output | 1 | Memory access request |
| mem_we_o | output | 1 | Memory access is a write |
| mem_addr_o | output | 32 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_ack_i | input | 1 | Memory access complete |
| mem_rdata_i | input | 32 | Memory read data, valid with mem_ack_i |

## Verification
The hardest situations to reach are the interleavings of status write-back with the present and permission bits. For example, a directory entry with its accessed flag clear can point to a table entry that is absent, or a write request can meet an already-accessed table entry, which must leave memory unchanged. The bench therefore sweeps all 256 flag combinations of the two levels. It crosses each combination with read/write, both privilege extremes and write-protect, and flushes before every walk, so that each case is a cold miss. Each present translation is requested a second time to confirm the cached copy. Slot conflicts are then forced with two pages whose page numbers share their low bits.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  localparam int unsigned PTE_P = 0;
  localparam int unsigned PTE_W = 1;
  localparam int unsigned PTE_U = 2;
  localparam int unsigned PTE_A = 5;
  localparam int unsigned PTE_D = 6;

  typedef enum logic [2:0] {
    S_IDLE,
    S_DIR_RD,
    S_DIR_WB,
    S_TBL_RD,
    S_TBL_WB,
    S_RESP
  } walk_state_e;

  function automatic logic [31:0] merge_entry(input logic [31:0] pde, input logic [31:0] pte,
                                              input logic wr);
    logic [31:0] e;
    e = pte;
    e[PTE_A] = 1'b1;
    if (wr) e[PTE_D] = 1'b1;
    e[PTE_W] = pte[PTE_W] & pde[PTE_W];
    e[PTE_U] = pte[PTE_U] & pde[PTE_U];
    return e;
  endfunction
endpackage

// File: rtl/pw_tlb.sv
module pw_tlb #(
  parameter int unsigned ENTRIES = 8,
  parameter int unsigned VPN_W   = 20,
  parameter int unsigned DATA_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [VPN_W-1:0]  lk_vpn_i,
  output logic              lk_hit_o,
  output logic [DATA_W-1:0] lk_entry_o,
  input  logic              fill_i,
  input  logic [VPN_W-1:0]  fill_vpn_i,
  input  logic [DATA_W-1:0] fill_entry_i,
  input  logic              flush_i
);
  localparam int unsigned IDX_W = $clog2(ENTRIES);
  localparam int unsigned TAG_W = VPN_W - IDX_W;

  logic [ENTRIES-1:0] valid_q;
  logic [TAG_W-1:0]   tag_q  [ENTRIES];
  logic [DATA_W-1:0]  data_q [ENTRIES];
  logic [ENTRIES-1:0] slot_hit;
  logic [DATA_W-1:0]  slot_data [ENTRIES];

  logic [IDX_W-1:0] lk_idx, fill_idx;
  logic [TAG_W-1:0] lk_tag;
  assign lk_idx   = lk_vpn_i[IDX_W-1:0];
  assign lk_tag   = lk_vpn_i[VPN_W-1:IDX_W];
  assign fill_idx = fill_vpn_i[IDX_W-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= '0;
    end else if (flush_i) begin
      valid_q <= '0;
    end else if (fill_i) begin
      valid_q[fill_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (fill_i && !flush_i) begin
      tag_q[fill_idx]  <= fill_vpn_i[VPN_W-1:IDX_W];
      data_q[fill_idx] <= fill_entry_i;
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    assign slot_hit[i]  = valid_q[i] && (lk_idx == IDX_W'(i)) && (tag_q[i] == lk_tag);
    assign slot_data[i] = slot_hit[i] ? data_q[i] : '0;
  end

  always_comb begin
    lk_entry_o = '0;
    for (int i = 0; i < ENTRIES; i++) lk_entry_o = lk_entry_o | slot_data[i];
  end
  assign lk_hit_o = |slot_hit;

  a_r10_flush_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> !lk_hit_o);
  a_r9_fill_visible: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_i && !flush_i) |=> (lk_vpn_i != $past(fill_vpn_i)) || lk_hit_o);
  a_r9_single_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(slot_hit));
endmodule

// File: rtl/pw_fault.sv
module pw_fault #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned PRIV_W = 2
) (
  input  logic [DATA_W-1:0] entry_i,
  input  logic              write_i,
  input  logic [PRIV_W-1:0] priv_i,
  input  logic              wp_en_i,
  output logic              fault_o,
  output logic [2:0]        err_o
);
  import pt_walker_pkg::*;
  logic not_present, user_viol, write_viol;
  assign not_present = !entry_i[PTE_P];
  assign user_viol   = !entry_i[PTE_U] && (priv_i != '0);
  assign write_viol  = write_i && wp_en_i && !entry_i[PTE_W];
  assign fault_o     = not_present | user_viol | write_viol;
  assign err_o       = entry_i[2:0];
endmodule

// File: rtl/pw_fsm.sv
module pw_fsm #(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned PRIV_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              write_i,
  input  logic [PRIV_W-1:0] priv_i,
  input  logic              wp_en_i,
  input  logic [ADDR_W-1:0] dir_base_i,
  input  logic              hit_i,
  input  logic [31:0]       hit_entry_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [31:0]       entry_o,
  output logic              write_o,
  output logic [PRIV_W-1:0] priv_o,
  output logic              wp_en_o,
  output logic              fill_o,
  output logic [19:0]       fill_vpn_o,
  output logic [31:0]       fill_entry_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i
);
  import pt_walker_pkg::*;

  walk_state_e       state_q;
  logic [19:0]       vpn_q;
  logic [ADDR_W-1:0] base_q;
  logic [31:0]       pde_q, pte_q, entry_q;
  logic              write_q, wp_q;
  logic [PRIV_W-1:0] priv_q;

  logic [ADDR_W-1:0] pde_addr, pte_addr;
  logic [31:0]       pde_wb, pte_wb, tbl_src;

  assign pde_addr = base_q + ADDR_W'({vpn_q[19:10], 2'b00});
  assign pte_addr = ADDR_W'({pde_q[31:12], 12'h000}) + ADDR_W'({vpn_q[9:0], 2'b00});

  always_comb begin
    pde_wb = pde_q;
    pde_wb[PTE_A] = 1'b1;
    pte_wb = pte_q;
    pte_wb[PTE_A] = 1'b1;
    if (write_q) pte_wb[PTE_D] = 1'b1;
  end

  always_comb begin
    mem_req_o   = 1'b0;
    mem_we_o    = 1'b0;
    mem_addr_o  = pde_addr;
    mem_wdata_o = pde_wb;
    unique case (state_q)
      S_DIR_RD: mem_req_o = 1'b1;
      S_DIR_WB: begin mem_req_o = 1'b1; mem_we_o = 1'b1; end
      S_TBL_RD: begin mem_req_o = 1'b1; mem_addr_o = pte_addr; end
      S_TBL_WB: begin
        mem_req_o = 1'b1; mem_we_o = 1'b1; mem_addr_o = pte_addr; mem_wdata_o = pte_wb;
      end
      default: ;
    endcase
  end

  // table entry feeding the merge: live read data or the written-back copy
  assign tbl_src      = (state_q == S_TBL_RD) ? mem_rdata_i : pte_q;
  assign fill_entry_o = merge_entry(pde_q, tbl_src, write_q);
  assign fill_vpn_o   = vpn_q;
  assign fill_o       = mem_ack_i && (
                          (state_q == S_TBL_WB) ||
                          (state_q == S_TBL_RD && mem_rdata_i[PTE_P] && mem_rdata_i[PTE_A]));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      vpn_q   <= '0;
      base_q  <= '0;
      pde_q   <= '0;
      pte_q   <= '0;
      entry_q <= '0;
      write_q <= 1'b0;
      wp_q    <= 1'b0;
      priv_q  <= '0;
    end else begin
      unique case (state_q)
        S_IDLE: if (start_i) begin
          vpn_q   <= addr_i[ADDR_W-1:12];
          base_q  <= dir_base_i;
          write_q <= write_i;
          priv_q  <= priv_i;
          wp_q    <= wp_en_i;
          if (hit_i) begin
            entry_q <= hit_entry_i;
            state_q <= S_RESP;
          end else begin
            state_q <= S_DIR_RD;
          end
        end
        S_DIR_RD: if (mem_ack_i) begin
          pde_q <= mem_rdata_i;
          if (!mem_rdata_i[PTE_P]) begin
            entry_q <= '0;
            state_q <= S_RESP;
          end else if (!mem_rdata_i[PTE_A]) begin
            state_q <= S_DIR_WB;
          end else begin
            state_q <= S_TBL_RD;
          end
        end
        S_DIR_WB: if (mem_ack_i) state_q <= S_TBL_RD;
        S_TBL_RD: if (mem_ack_i) begin
          pte_q <= mem_rdata_i;
          if (!mem_rdata_i[PTE_P]) begin
            entry_q <= '0;
            state_q <= S_RESP;
          end else if (!mem_rdata_i[PTE_A]) begin
            state_q <= S_TBL_WB;
          end else begin
            entry_q <= fill_entry_o;
            state_q <= S_RESP;
          end
        end
        S_TBL_WB: if (mem_ack_i) begin
          entry_q <= fill_entry_o;
          state_q <= S_RESP;
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign busy_o  = (state_q != S_IDLE);
  assign done_o  = (state_q == S_RESP);
  assign entry_o = entry_q;
  assign write_o = write_q;
  assign priv_o  = priv_q;
  assign wp_en_o = wp_q;

  a_r11_hold_until_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)
                                   && $stable(mem_wdata_o));
  a_r5_wb_sets_accessed: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o) |-> mem_wdata_o[PTE_A]);
  a_r5_wb_same_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && mem_we_o && !$past(mem_we_o) && $past(mem_req_o)) |->
      mem_addr_o == $past(mem_addr_o));
  a_r9_fill_present: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_o |-> fill_entry_o[PTE_P]);
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int unsigned TLB_ENTRIES = 8,
  parameter int unsigned ADDR_W      = 32,
  parameter int unsigned PRIV_W      = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic              req_write_i,
  input  logic [PRIV_W-1:0] req_priv_i,
  input  logic [ADDR_W-1:0] dir_base_i,
  input  logic              wp_en_i,
  input  logic              flush_i,
  output logic              busy_o,
  output logic              resp_valid_o,
  output logic [31:0]       resp_entry_o,
  output logic              resp_fault_o,
  output logic [2:0]        resp_err_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [31:0]       mem_rdata_i
);
  localparam int unsigned VPN_W = ADDR_W - 12;

  logic              hit, fill, start, q_write, q_wp;
  logic [31:0]       hit_entry, fill_entry;
  logic [19:0]       fill_vpn;
  logic [PRIV_W-1:0] q_priv;

  assign start = req_valid_i && !busy_o;

  pw_tlb #(.ENTRIES(TLB_ENTRIES), .VPN_W(VPN_W), .DATA_W(32)) u_tlb (
    .clk_i, .rst_ni,
    .lk_vpn_i(req_addr_i[ADDR_W-1:12]), .lk_hit_o(hit), .lk_entry_o(hit_entry),
    .fill_i(fill), .fill_vpn_i(fill_vpn), .fill_entry_i(fill_entry), .flush_i
  );

  pw_fsm #(.ADDR_W(ADDR_W), .PRIV_W(PRIV_W)) u_fsm (
    .clk_i, .rst_ni, .start_i(start), .addr_i(req_addr_i), .write_i(req_write_i),
    .priv_i(req_priv_i), .wp_en_i, .dir_base_i, .hit_i(hit), .hit_entry_i(hit_entry),
    .busy_o, .done_o(resp_valid_o), .entry_o(resp_entry_o), .write_o(q_write),
    .priv_o(q_priv), .wp_en_o(q_wp), .fill_o(fill), .fill_vpn_o(fill_vpn),
    .fill_entry_o(fill_entry), .mem_req_o, .mem_we_o, .mem_addr_o, .mem_wdata_o,
    .mem_ack_i, .mem_rdata_i
  );

  pw_fault #(.DATA_W(32), .PRIV_W(PRIV_W)) u_fault (
    .entry_i(resp_entry_o), .write_i(q_write), .priv_i(q_priv), .wp_en_i(q_wp),
    .fault_o(resp_fault_o), .err_o(resp_err_o)
  );

  a_r2_resp_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o);
  a_r4_absent_faults: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (resp_valid_o && !resp_entry_o[0]) |-> resp_fault_o && resp_entry_o == 32'h0);
  a_r11_no_mem_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !mem_req_o);
  a_r2_hit_no_mem: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && hit) |=> resp_valid_o && !mem_req_o);
endmodule

// File: tb/tb_pt_walker.sv
module tb_pt_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0, wp_en = 1'b0, flush = 1'b0;
  logic [31:0] req_addr = '0, dir_base = 32'h0000_2000;
  logic [1:0]  req_priv = '0;
  logic        busy, resp_valid, resp_fault, mem_req, mem_we;
  logic [31:0] resp_entry, mem_addr, mem_wdata;
  logic [2:0]  resp_err;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  pt_walker dut (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_addr_i(req_addr),
    .req_write_i(req_write), .req_priv_i(req_priv), .dir_base_i(dir_base), .wp_en_i(wp_en),
    .flush_i(flush), .busy_o(busy), .resp_valid_o(resp_valid), .resp_entry_o(resp_entry),
    .resp_fault_o(resp_fault), .resp_err_o(resp_err), .mem_req_o(mem_req), .mem_we_o(mem_we),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_ack_i(mem_ack), .mem_rdata_i(mem_rdata)
  );

  always #5 clk = ~clk;

  int n_checks = 0, n_fail = 0, cyc = 0, acc_cnt = 0;
  logic [31:0] mem [4096];
  logic [31:0] log_addr [8];
  logic        log_we [8];

  always @(posedge clk) begin
    if (mem_req && !mem_ack) begin
      mem_ack   <= 1'b1;
      mem_rdata <= mem[mem_addr[13:2]];
      if (mem_we) mem[mem_addr[13:2]] <= mem_wdata;
      log_addr[acc_cnt % 8] <= mem_addr;
      log_we[acc_cnt % 8]   <= mem_we;
      acc_cnt <= acc_cnt + 1;
    end else begin
      mem_ack <= 1'b0;
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got %0d cycles exp below 150000", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: got %h exp %h", tag, what, got, exp);
    end
  endtask

  logic [31:0] r_entry;
  logic        r_fault;
  logic [2:0]  r_err;

  task automatic do_req(input logic [31:0] a, input bit w, input logic [1:0] pv,
                        input bit wp, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_write = w; req_priv = pv; wp_en = wp;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!resp_valid && lat < 60) begin
      @(negedge clk);
      lat++;
    end
    chk(lat < 60, "R11", "response timeout", lat, 60);
    r_entry = resp_entry; r_fault = resp_fault; r_err = resp_err;
  endtask

  task automatic do_flush();
    @(negedge clk); flush = 1'b1;
    @(negedge clk); flush = 1'b0;
  endtask

  function automatic bit exp_fault(input logic [31:0] e, input bit w, input logic [1:0] pv,
                                   input bit wp);
    return !e[0] || (!e[2] && pv != 2'd0) || (w && wp && !e[1]);
  endfunction

  localparam logic [31:0] VA_A = 32'h0040_3000;  // dir idx 1, table idx 3
  localparam logic [31:0] VA_B = 32'h0080_B000;  // dir idx 2, table idx 11, same slot as A

  initial begin
    int lat, base;
    for (int i = 0; i < 4096; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk(!resp_valid && !mem_req && !busy, "R1", "outputs in reset",
        {29'b0, resp_valid, mem_req, busy}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!resp_valid && !mem_req && !busy, "R1", "idle after reset",
        {29'b0, resp_valid, mem_req, busy}, 0);

    for (int combo = 0; combo < 256; combo++) begin
      for (int w = 0; w < 2; w++) begin
        for (int pi = 0; pi < 2; pi++) begin
          for (int wp = 0; wp < 2; wp++) begin
            logic [31:0] pde, pte, e, exp_pte_mem, exp_pde_mem;
            logic [1:0] pv;
            bit dp, da, tp, ta, full;
            int exp_acc;
            pv = (pi != 0) ? 2'd3 : 2'd0;
            dp = combo[0]; da = combo[3]; tp = combo[4]; ta = combo[7];
            pde = 32'h0000_1000;
            pde[0] = combo[0]; pde[1] = combo[1]; pde[2] = combo[2]; pde[5] = combo[3];
            pte = 32'hABCD_E000;
            pte[0] = combo[4]; pte[1] = combo[5]; pte[2] = combo[6]; pte[5] = combo[7];
            mem[12'h801] = pde;
            mem[12'h403] = pte;
            do_flush();
            base = acc_cnt;
            do_req(VA_A, w[0], pv, wp[0], lat);
            full = dp && tp;
            if (full) begin
              e = pte; e[5] = 1'b1; if (w != 0) e[6] = 1'b1;
              e[1] = pte[1] & pde[1]; e[2] = pte[2] & pde[2];
            end else e = '0;
            exp_acc = 1 + (dp && !da) + (dp ? 1 + (tp && !ta) : 0);
            chk(r_entry == e, full ? "R7" : "R4", "entry", r_entry, e);
            chk(r_entry[6] == (full && w != 0), "R6", "dirty bit", r_entry, e);
            chk(r_fault == exp_fault(e, w[0], pv, wp[0]) && r_err == e[2:0], "R8",
                "fault/err", {28'b0, r_fault, r_err}, {28'b0, exp_fault(e, w[0], pv, wp[0]), e[2:0]});
            chk(acc_cnt - base == exp_acc, "R5", "access count", acc_cnt - base, exp_acc);
            exp_pde_mem = pde; if (dp) exp_pde_mem[5] = 1'b1;
            exp_pte_mem = pte;
            if (full && !ta) begin exp_pte_mem[5] = 1'b1; if (w != 0) exp_pte_mem[6] = 1'b1; end
            chk(mem[12'h801] == exp_pde_mem, "R5", "directory in memory", mem[12'h801], exp_pde_mem);
            chk(mem[12'h403] == exp_pte_mem, "R6", "table in memory", mem[12'h403], exp_pte_mem);
            chk(log_addr[base % 8] == 32'h2004 && !log_we[base % 8], "R3", "directory address",
                log_addr[base % 8], 32'h2004);
            if (dp) begin
              int k;
              k = (base + 1 + (da ? 0 : 1)) % 8;
              chk(log_addr[k] == 32'h100C && !log_we[k], "R3", "table address",
                  log_addr[k], 32'h100C);
            end
            if (full) begin
              base = acc_cnt;
              do_req(VA_A, w[0], pv, wp[0], lat);
              chk(lat == 0 && acc_cnt == base, "R2", "hit latency/accesses",
                  lat * 256 + (acc_cnt - base), 0);
              chk(r_entry == e, "R2", "hit entry", r_entry, e);
            end
          end
        end
      end
    end

    // R9: slot conflict and not-present never cached
    mem[12'h801] = 32'h0000_1027;
    mem[12'h403] = 32'h1111_1027;
    mem[12'h802] = 32'h0000_1027;
    mem[12'h40B] = 32'h2222_2027;
    do_flush();
    base = acc_cnt; do_req(VA_A, 1'b0, 2'd0, 1'b0, lat);
    chk(acc_cnt - base == 2 && r_entry == 32'h1111_1027, "R9", "A cold miss", r_entry, 32'h1111_1027);
    base = acc_cnt; do_req(VA_B, 1'b0, 2'd0, 1'b0, lat);
    chk(acc_cnt - base == 2 && r_entry == 32'h2222_2027, "R9", "B miss", r_entry, 32'h2222_2027);
    base = acc_cnt; do_req(VA_A, 1'b0, 2'd0, 1'b0, lat);
    chk(acc_cnt - base == 2, "R9", "A evicted by B", acc_cnt - base, 2);
    base = acc_cnt; do_req(VA_A, 1'b0, 2'd3, 1'b0, lat);
    chk(acc_cnt - base == 0 && lat == 0 && !r_fault, "R2", "A hit", acc_cnt - base, 0);
    do_flush();
    base = acc_cnt; do_req(VA_A, 1'b0, 2'd0, 1'b0, lat);
    chk(acc_cnt - base == 2, "R10", "miss after flush", acc_cnt - base, 2);
    mem[12'h403] = 32'h1111_1026;
    do_flush();
    for (int rep = 0; rep < 2; rep++) begin
      base = acc_cnt; do_req(VA_A, 1'b0, 2'd0, 1'b0, lat);
      chk(acc_cnt - base == 2 && r_entry == 0 && r_fault, "R9", "absent page walked again",
          acc_cnt - base, 2);
    end

    summary();
    $finish;
  end
endmodule